// File: doc/BRIEF.md
# Video stream depacketizer with sync regeneration

This block sits behind a word aligner on the receive side of a serial video link. It takes a stream of aligned 32-bit words, each with a per-byte K-character flag and a valid strobe, and sorts each word into one of two kinds: a framing command or payload. From the commands it rebuilds a vertical sync level and the boundaries of each video line. It drops blanking filler and unknown commands. It removes the line-number word that opens each line and sends that number out separately so that line order can be checked. Each payload word inside a line becomes two 16-bit pixels with a data-valid strobe.

A command is a word whose K-flags mark only byte 0 and whose byte 0 is the comma character 0xBC. Bits [15:8] of a command carry its opcode, and bits [31:16] are ignored. The link side must leave at least one idle cycle between valid words. Each word yields two output pixels on two consecutive cycles, so the output needs that idle cycle to keep up.

Top module: `vid_depack`

## Requirements
- R1: A valid word is a command only when `kflag_i` is 4'b0001 and `word_i[7:0]` is 0xBC. Its opcode is `word_i[15:8]`. Every other valid word is payload, including words with any other K-flag pattern.
- R2: A frame-start-0 command (opcode 0x10) drives `vsync_o` high from the next cycle. A frame-start-1 command (opcode 0x11) drives it low from the next cycle.
- R3: After a line-start command (opcode 0x20), the next payload word is the line number. Its low 16 bits appear on `line_num_o` in the following cycle and stay there until the next line number arrives.
- R4: Each payload word that arrives after the line number and before a line-end command (opcode 0x21) gives two pixels. Bits [15:0] appear on `pix_o` with `de_o` high in the cycle after the word. Bits [31:16] appear with `de_o` high in the cycle after that.
- R5: `de_o` is low at all other times. The line-number word and any payload that arrives outside an open line produce no pixels.
- R6: The filler commands (opcodes 0x30 and 0x31) and commands with unknown opcodes are dropped. They change no output.
- R7: A frame-end-0 command (opcode 0x40) closes the frame when the next valid word is a frame-end-1 command (opcode 0x41). Closing the frame closes any open line and clears the line-number history. A frame-end-1 command that does not directly follow a frame-end-0 command is ignored.
- R8: A line-start command that arrives while a line is open, from its line-start until its line-end, raises `line_err_o` for one cycle in the next cycle. The old line is closed and the new line waits for its number.
- R9: `seq_err_o` pulses for one cycle in the cycle after a line number that is not the previous number plus one, counted modulo 2^16. Only numbers received since the last frame-start-0 command or frame close count as previous. The first number after either of these is not checked.
- R10: A word with `valid_i` low has no effect.
- R11: While reset is asserted and afterwards until a word arrives, `vsync_o`, `de_o`, `line_err_o` and `seq_err_o` are low and `line_num_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Aligned received word |
| kflag_i | input | 4 | Per-byte K-character flags |
| valid_i | input | 1 | Word strobe, at most every other cycle |
| pix_o | output | 16 | Pixel data |
| de_o | output | 1 | Pixel data valid |
| vsync_o | output | 1 | Regenerated vertical sync |
| line_num_o | output | 16 | Last received line number |
| line_err_o | output | 1 | Line restarted while still open |
| seq_err_o | output | 1 | Line number out of sequence |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 16-bit line number and the 0xBC comma. At these values the line number can wrap from 0xFFFF to 0x0000, so the modulo rule of the sequence check is within reach. The opcode field sits in byte 1, where a word that carries a comma in another byte, or that has other K-flags, must still pass through as pixels. The stimulus includes nested line-starts, a frame-end pair broken up by filler, a frame-end-1 on its own, and command-shaped words sent with the strobe low.

// File: rtl/vid_depack_pkg.sv
package vid_depack_pkg;

  localparam logic [7:0] OP_FS0  = 8'h10;
  localparam logic [7:0] OP_FS1  = 8'h11;
  localparam logic [7:0] OP_LS   = 8'h20;
  localparam logic [7:0] OP_LE   = 8'h21;
  localparam logic [7:0] OP_FE0  = 8'h40;
  localparam logic [7:0] OP_FE1  = 8'h41;

  typedef struct packed {
    logic valid;
    logic fs0;
    logic fs1;
    logic ls;
    logic le;
    logic fe0;
    logic fe1;
    logic payload;
  } ev_t;

endpackage

// File: rtl/vid_depack_decode.sv
module vid_depack_decode
  import vid_depack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [7:0] COMMA = 8'hBC,
  localparam int K_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [K_W-1:0]    kflag_i,
  input  logic              valid_i,
  output ev_t               ev_o
);

  logic       is_cmd;
  logic [7:0] op;

  always_comb begin
    is_cmd = valid_i && (kflag_i == K_W'(1)) && (word_i[7:0] == COMMA);
    op     = word_i[15:8];
    ev_o         = '0;
    ev_o.valid   = valid_i;
    ev_o.payload = valid_i && !is_cmd;
    if (is_cmd) begin
      unique case (op)
        OP_FS0:  ev_o.fs0 = 1'b1;
        OP_FS1:  ev_o.fs1 = 1'b1;
        OP_LS:   ev_o.ls  = 1'b1;
        OP_LE:   ev_o.le  = 1'b1;
        OP_FE0:  ev_o.fe0 = 1'b1;
        OP_FE1:  ev_o.fe1 = 1'b1;
        default: ;  // filler and unknown opcodes: dropped
      endcase
    end
  end

endmodule

// File: rtl/vid_depack_track.sv
module vid_depack_track
  import vid_depack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ev_t               ev_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              take_o,
  output logic              vsync_o,
  output logic [LINE_W-1:0] line_num_o,
  output logic              line_err_o,
  output logic              seq_err_o
);

  logic              vsync_q, need_num_q, open_q, fe_pend_q, have_prev_q;
  logic [LINE_W-1:0] line_q;
  logic              line_err_q, seq_err_q;
  logic [LINE_W-1:0] num_in;

  assign num_in = word_i[LINE_W-1:0];
  assign take_o = ev_i.payload && open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsync_q     <= 1'b0;
      need_num_q  <= 1'b0;
      open_q      <= 1'b0;
      fe_pend_q   <= 1'b0;
      have_prev_q <= 1'b0;
      line_q      <= '0;
      line_err_q  <= 1'b0;
      seq_err_q   <= 1'b0;
    end else begin
      line_err_q <= 1'b0;
      seq_err_q  <= 1'b0;
      if (ev_i.valid) begin
        fe_pend_q <= ev_i.fe0;
        if (ev_i.fs0) begin
          vsync_q     <= 1'b1;
          have_prev_q <= 1'b0;
        end
        if (ev_i.fs1) vsync_q <= 1'b0;
        if (ev_i.ls) begin
          line_err_q <= need_num_q | open_q;
          need_num_q <= 1'b1;
          open_q     <= 1'b0;
        end
        if (ev_i.le) begin
          need_num_q <= 1'b0;
          open_q     <= 1'b0;
        end
        if (ev_i.fe1 && fe_pend_q) begin
          need_num_q  <= 1'b0;
          open_q      <= 1'b0;
          have_prev_q <= 1'b0;
        end
        if (ev_i.payload && need_num_q) begin
          line_q      <= num_in;
          need_num_q  <= 1'b0;
          open_q      <= 1'b1;
          have_prev_q <= 1'b1;
          seq_err_q   <= have_prev_q && (num_in != line_q + LINE_W'(1));
        end
      end
    end
  end

  assign vsync_o    = vsync_q;
  assign line_num_o = line_q;
  assign line_err_o = line_err_q;
  assign seq_err_o  = seq_err_q;

  p_vsync_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.fs0 |=> vsync_o);
  p_vsync_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.fs1 |=> !vsync_o);
  p_line_err_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_err_o |-> $past(ev_i.ls));
  p_seq_err_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> $past(ev_i.payload));

endmodule

// File: rtl/vid_depack_unpack.sv
module vid_depack_unpack #(
  parameter int DATA_W = 32,
  localparam int PIX_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              de_o
);

  logic [PIX_W-1:0] pix_q, hi_q;
  logic             de_q, hi_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q     <= '0;
      hi_q      <= '0;
      de_q      <= 1'b0;
      hi_pend_q <= 1'b0;
    end else if (take_i) begin
      pix_q     <= data_i[PIX_W-1:0];
      hi_q      <= data_i[DATA_W-1:PIX_W];
      de_q      <= 1'b1;
      hi_pend_q <= 1'b1;
    end else if (hi_pend_q) begin
      pix_q     <= hi_q;
      de_q      <= 1'b1;
      hi_pend_q <= 1'b0;
    end else begin
      de_q <= 1'b0;
    end
  end

  assign pix_o = pix_q;
  assign de_o  = de_q;

  p_low_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (de_o && pix_o == $past(data_i[PIX_W-1:0])));
  p_high_second_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> ##1 (de_o && pix_o == $past(data_i[DATA_W-1:PIX_W], 2)));

endmodule

// File: rtl/vid_depack.sv
module vid_depack
  import vid_depack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINE_W = 16,
  parameter logic [7:0] COMMA = 8'hBC,
  localparam int K_W   = DATA_W / 8,
  localparam int PIX_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic [K_W-1:0]    kflag_i,
  input  logic              valid_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              de_o,
  output logic              vsync_o,
  output logic [LINE_W-1:0] line_num_o,
  output logic              line_err_o,
  output logic              seq_err_o
);

  ev_t  ev;
  logic take;

  vid_depack_decode #(.DATA_W(DATA_W), .COMMA(COMMA)) u_decode (
    .word_i (word_i),
    .kflag_i(kflag_i),
    .valid_i(valid_i),
    .ev_o   (ev)
  );

  vid_depack_track #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .word_i    (word_i),
    .take_o    (take),
    .vsync_o   (vsync_o),
    .line_num_o(line_num_o),
    .line_err_o(line_err_o),
    .seq_err_o (seq_err_o)
  );

  vid_depack_unpack #(.DATA_W(DATA_W)) u_unpack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .data_i(word_i),
    .pix_o (pix_o),
    .de_o  (de_o)
  );

  // Input contract behind R4: two pixels out per word needs an idle cycle.
  p_word_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

endmodule

// File: tb/vid_depack_bench.sv
module vid_depack_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word = '0;
  logic [3:0]  kf = '0;
  logic        vld = 1'b0;
  logic [15:0] pix, lnum;
  logic        de, vs, lerr, serr;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  vid_depack u_vid_depack (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .kflag_i(kf), .valid_i(vld),
    .pix_o(pix), .de_o(de), .vsync_o(vs), .line_num_o(lnum),
    .line_err_o(lerr), .seq_err_o(serr)
  );

  // Reference model built from the requirements.
  int   pq[$];
  bit   m_vs, m_open, m_need, m_fe, m_prev, m_lerr, m_serr, e_de;
  int   m_line, e_pix;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq.delete();
      m_vs = 0; m_open = 0; m_need = 0; m_fe = 0; m_prev = 0;
      m_lerr = 0; m_serr = 0; e_de = 0; m_line = 0; e_pix = 0;
    end else begin
      bit is_cmd, fe_now;
      int op;
      m_lerr = 0; m_serr = 0; fe_now = 0;
      if (vld) begin  // R10: no valid, no effect
        is_cmd = (kf == 4'b0001) && (word[7:0] == 8'hBC);  // R1
        op = int'(word[15:8]);
        if (is_cmd) begin
          case (op)
            'h10: begin m_vs = 1; m_prev = 0; end            // R2
            'h11: m_vs = 0;                                  // R2
            'h20: begin m_lerr = m_open || m_need; m_need = 1; m_open = 0; end  // R8
            'h21: begin m_need = 0; m_open = 0; end
            'h40: fe_now = 1;
            'h41: if (m_fe) begin m_open = 0; m_need = 0; m_prev = 0; end  // R7
            default: ;  // R6
          endcase
        end else if (m_need) begin                           // R3, R9
          int num;
          num = int'(word[15:0]);
          m_serr = m_prev && (num != ((m_line + 1) % 65536));
          m_line = num; m_need = 0; m_open = 1; m_prev = 1;
        end else if (m_open) begin                           // R4
          pq.push_back(int'(word[15:0]));
          pq.push_back(int'(word[31:16]));
        end
        m_fe = fe_now;
      end
      if (pq.size() > 0) begin e_de = 1; e_pix = pq.pop_front(); end
      else e_de = 0;                                          // R5
    end
  end

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      vectors++;
      cmp("R2 vsync", int'(vs), int'(m_vs));
      cmp("R3 line_num", int'(lnum), m_line);
      cmp("R4/R5 de", int'(de), int'(e_de));
      if (e_de) cmp("R4 pix", int'(pix), e_pix);
      cmp("R8 line_err", int'(lerr), int'(m_lerr));
      cmp("R9 seq_err", int'(serr), int'(m_serr));
      if (!rst_n) cmp("R11 reset de/vs/errs", int'({de, vs, lerr, serr}), 0);
    end
  end

  task automatic put(logic [3:0] k, logic [31:0] w, int gap);
    @(negedge clk);
    vld = 1'b1; word = w; kf = k;
    @(negedge clk);
    vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] op);
    put(4'b0001, {16'hA5A5, op, 8'hBC}, 0);
  endtask

  task automatic pay(logic [31:0] w);
    put(4'b0000, w, 0);
  endtask

  task automatic line(int num, int words, int seed);
    cmd(8'h20);
    pay({16'h0, num[15:0]});
    for (int i = 0; i < words; i++) pay(32'(seed * 32'h01010101 + i * 32'h00170023));
    cmd(8'h21);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;                      // R11 checked during reset and idle after
    repeat (3) @(negedge clk);
    cmd(8'h10);                        // R2 rise
    cmd(8'h30); cmd(8'h31);            // R6 filler
    cmd(8'h11);                        // R2 fall
    line(0, 3, 1);
    cmd(8'h30);
    line(1, 4, 2);
    line(2, 1, 3);
    pay(32'hDEAD_BEEF);                // R5 payload outside a line
    cmd(8'h77);                        // R6 unknown opcode
    // R1: comma in byte 0 but other K pattern, and K pattern with other byte: payload
    cmd(8'h20); pay(32'h3);
    put(4'b0011, 32'h1234_20BC, 0);
    put(4'b0001, 32'h1234_20BD, 1);
    put(4'b0010, 32'h0000_BC00, 0);
    cmd(8'h21);
    // R10: command-shaped words with strobe low
    @(negedge clk); word = 32'h0000_20BC; kf = 4'b0001;
    repeat (3) @(negedge clk);
    word = 32'h0000_10BC; @(negedge clk); @(negedge clk);
    // R8: line-start while open, twice (once while waiting for number)
    cmd(8'h20); pay(32'h4); pay(32'h1111_2222);
    cmd(8'h20); cmd(8'h20); pay(32'h5); pay(32'h3333_4444); cmd(8'h21);
    // R9: skipped number, then wrap
    line(9, 1, 4);
    line(16'hFFFF, 1, 5);
    line(0, 1, 6);
    // R7: lone frame-end-1 ignored; broken pair ignored; real pair closes
    cmd(8'h41); line(7, 1, 7);
    cmd(8'h40); cmd(8'h30); cmd(8'h41); line(100, 1, 8);
    cmd(8'h20); pay(32'd101); pay(32'hABCD_0123);
    cmd(8'h40); cmd(8'h41);            // closes open line
    pay(32'h5555_6666);                // dropped
    line(50, 2, 9);                    // first after close: no R9 error
    line(52, 1, 10);                   // R9 error
    cmd(8'h10); line(3, 1, 11); cmd(8'h11);  // R2 again, R9 history cleared
    repeat (6) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(negedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule